// File: doc/BRIEF.md
# Debug Counter with Breakpoint Match

This block is the shared 16-bit counter register of an on-chip debug unit for a small processor core. One register serves three jobs. It counts down the bytes left in a debug register or memory transfer. It counts down the clock cycles during which the core executes. It also acts as a one-shot hardware breakpoint that is compared against the program counter. The counter only ever moves downward. Every read returns the bitwise inverse of the stored value, so a count that starts from all ones appears to the host as an elapsed count that rises from zero.

A host talks to the block through a byte-wide command path. Command and data bytes arrive on separate strobes, and response bytes come back on a registered output strobe. The block decodes four command bytes: revision, counter write, status and counter read. Counter writes and counter reads are honoured only while the core is in debug mode. Because other debug commands reuse the register, a breakpoint value must be the last thing written before debug mode is left.

Top module: `dbgCounter`

## Requirements
- R1: After an active-high synchronous reset, the counter holds 0000h, the mode is idle, `rdValid` is low and `brkReq` is low.
- R2: Command byte 00h returns the parameter `REV_ID` (default 8'h4C) as one response byte. The byte appears in the cycle after the command is taken. This works in and out of debug mode.
- R3: Command byte 02h returns one status byte. Bit 0 is `debugMode`, bits 2:1 are the mode code, and the other bits are zero. Mode codes are 0 idle, 1 byte count, 2 cycle count and 3 breakpoint.
- R4: Command byte 01h, taken in debug mode, consumes three data bytes: counter high byte, counter low byte, then a mode byte whose bits 1:0 give the mode code. The counter is loaded when the low byte is taken.
- R5: Command byte 03h, taken in debug mode, returns two response bytes on consecutive cycles. The first is the inverted high byte and the second the inverted low byte, both captured when the command is taken.
- R6: In byte-count mode the counter decrements once per `xferByte` strobe and holds at zero.
- R7: Selecting cycle-count mode loads FFFFh, whatever value was written before the mode byte. The counter then decrements on every clock with `cpuRun` high and holds at zero without wrapping.
- R8: In breakpoint mode the counter does not change. `brkReq` is high, in the same cycle, when `cpuRun` and `fetchStrobe` are high and `pc` equals the counter. The same clock edge returns the mode to idle, so the request lasts a single cycle.
- R9: Apart from a counter write or a cycle-count selection, the counter never increases.
- R10: Commands 01h and 03h outside debug mode are ignored, and so are all command bytes above 03h. An ignored command sends no response and leaves the counter and the mode unchanged. In idle mode the `xferByte` and `cpuRun` strobes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte |
| dataValid | input | 1 | Data byte strobe for counter writes |
| dataIn | input | 8 | Data byte |
| debugMode | input | 1 | Core is halted in debug mode |
| pc | input | 16 | Program counter of the instruction being fetched |
| cpuRun | input | 1 | Core is executing |
| fetchStrobe | input | 1 | An instruction at `pc` is about to execute |
| xferByte | input | 1 | One byte of a debug transfer has moved |
| rdValid | output | 1 | Response byte strobe |
| rdData | output | 8 | Response byte |
| brkReq | output | 1 | Break request pulse |

## Verification
A wrong count or mode shows up at the ports through a counter read, which exposes the inverted value two cycles after the command, or through a status read, which exposes the mode one cycle after the command. A breakpoint fault is visible at once on `brkReq` in the matching fetch cycle, and a mode that fails to clear shows as a second pulse on the next cycle. Decrement faults build up over many cycles, so the bench reads the counter after known runs of strobes and at the zero floor.

// File: rtl/dbgCounterPkg.sv
package dbgCounterPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_BYTES  = 2'd1,
    MODE_CYCLES = 2'd2,
    MODE_BREAK  = 2'd3
  } cntMode_e;

  localparam logic [BYTE_W-1:0] CMD_REV  = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_WR   = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_STAT = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_RD   = 8'h03;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic loadMode;
    logic respRev;
    logic respStat;
    logic respCntHi;
    logic respCntLo;
  } ctrlStrobes_t;
endpackage

// File: rtl/dbgCtrl.sv
module dbgCtrl
  import dbgCounterPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              dataValid,
  input  logic              debugMode,
  output ctrlStrobes_t      strobes
);
  typedef enum logic [2:0] {S_IDLE, S_WHI, S_WLO, S_WMODE, S_RLO} ctrlState_e;
  ctrlState_e state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      S_IDLE: if (cmdValid) begin
        case (cmdByte)
          CMD_REV:  strobes.respRev = 1'b1;
          CMD_STAT: strobes.respStat = 1'b1;
          CMD_WR:   if (debugMode) nextState = S_WHI;
          CMD_RD:   if (debugMode) begin
            strobes.respCntHi = 1'b1;
            nextState         = S_RLO;
          end
          default: ;
        endcase
      end
      S_WHI: if (dataValid) begin
        strobes.loadHi = 1'b1;
        nextState      = S_WLO;
      end
      S_WLO: if (dataValid) begin
        strobes.loadLo = 1'b1;
        nextState      = S_WMODE;
      end
      S_WMODE: if (dataValid) begin
        strobes.loadMode = 1'b1;
        nextState        = S_IDLE;
      end
      S_RLO: begin
        strobes.respCntLo = 1'b1;
        nextState         = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end
endmodule

// File: rtl/dbgPath.sv
module dbgPath
  import dbgCounterPkg::*;
#(
  parameter logic [BYTE_W-1:0] REV_ID = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              debugMode,
  input  logic [CNT_W-1:0]  pc,
  input  logic              cpuRun,
  input  logic              fetchStrobe,
  input  logic              xferByte,
  output logic [CNT_W-1:0]  cntValue,
  output cntMode_e          modeValue,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData,
  output logic              brkReq
);
  logic [BYTE_W-1:0] hiStage, lowShadow;
  logic [CNT_W-1:0]  cntNext;
  cntMode_e          modeNext;
  logic              decEn;

  assign brkReq = (modeValue == MODE_BREAK) && cpuRun && fetchStrobe && (pc == cntValue);
  assign decEn  = (cntValue != '0) &&
                  (((modeValue == MODE_BYTES) && xferByte) ||
                   ((modeValue == MODE_CYCLES) && cpuRun));

  always_comb begin
    cntNext  = cntValue;
    modeNext = modeValue;
    if (strobes.loadLo)
      cntNext = {hiStage, dataIn};
    else if (strobes.loadMode && (dataIn[1:0] == MODE_CYCLES))
      cntNext = '1;
    else if (decEn)
      cntNext = cntValue - 1'b1;
    if (strobes.loadMode) modeNext = cntMode_e'(dataIn[1:0]);
    else if (brkReq)      modeNext = MODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntValue  <= '0;
      modeValue <= MODE_IDLE;
      hiStage   <= '0;
      lowShadow <= '0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      cntValue  <= cntNext;
      modeValue <= modeNext;
      if (strobes.loadHi) hiStage <= dataIn;
      rdValid <= strobes.respRev | strobes.respStat | strobes.respCntHi | strobes.respCntLo;
      if (strobes.respRev)  rdData <= REV_ID;
      if (strobes.respStat) rdData <= {{(BYTE_W-3){1'b0}}, modeValue, debugMode};
      if (strobes.respCntHi) begin
        rdData    <= ~cntValue[CNT_W-1:BYTE_W];
        lowShadow <= ~cntValue[BYTE_W-1:0];
      end
      if (strobes.respCntLo) rdData <= lowShadow;
    end
  end
endmodule

// File: rtl/dbgCounter.sv
module dbgCounter
  import dbgCounterPkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h4C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  input  logic        dataValid,
  input  logic [7:0]  dataIn,
  input  logic        debugMode,
  input  logic [15:0] pc,
  input  logic        cpuRun,
  input  logic        fetchStrobe,
  input  logic        xferByte,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        brkReq
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] cntValue;
  cntMode_e         modeValue;

  dbgCtrl u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .debugMode(debugMode), .strobes(strobes)
  );

  dbgPath #(.REV_ID(REV_ID)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn),
    .debugMode(debugMode), .pc(pc), .cpuRun(cpuRun),
    .fetchStrobe(fetchStrobe), .xferByte(xferByte),
    .cntValue(cntValue), .modeValue(modeValue),
    .rdValid(rdValid), .rdData(rdData), .brkReq(brkReq)
  );
endmodule

// File: rtl/dbgCounterChk.sv
module dbgCounterChk
  import dbgCounterPkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             brkReq,
  input logic             cpuRun,
  input logic [CNT_W-1:0] cntValue,
  input cntMode_e         modeValue,
  input ctrlStrobes_t     strobes
);
  // R8
  brk_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    brkReq |=> !brkReq);

  // R8
  brk_clears_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (brkReq && !strobes.loadMode) |=> (modeValue == MODE_IDLE));

  // R8
  break_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((modeValue == MODE_BREAK) && !strobes.loadLo && !strobes.loadMode) |=> $stable(cntValue));

  // R9
  no_increment_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadLo && !strobes.loadMode) |=> (cntValue <= $past(cntValue)));

  // R7
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((modeValue == MODE_CYCLES) && cpuRun && (cntValue != '0) &&
     !strobes.loadLo && !strobes.loadMode) |=> (cntValue == $past(cntValue) - 1'b1));
endmodule

bind dbgCounter dbgCounterChk i_chk (
  .clk(clk), .rst(rst), .brkReq(brkReq), .cpuRun(cpuRun),
  .cntValue(cntValue), .modeValue(modeValue), .strobes(strobes)
);

// File: tb/test_dbgCounter.sv
module test_dbgCounter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0, dataValid = 1'b0, debugMode = 1'b1;
  logic [7:0]  cmdByte = '0, dataIn = '0;
  logic [15:0] pc = '0;
  logic        cpuRun = 1'b0, fetchStrobe = 1'b0, xferByte = 1'b0;
  logic        rdValid, brkReq;
  logic [7:0]  rdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbgCounter i_dbgCounter (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataIn(dataIn), .debugMode(debugMode),
    .pc(pc), .cpuRun(cpuRun), .fetchStrobe(fetchStrobe), .xferByte(xferByte),
    .rdValid(rdValid), .rdData(rdData), .brkReq(brkReq)
  );

  // {written value, expected inverted readback}
  localparam logic [31:0] VEC [6] = '{
    {16'h0000, 16'hFFFF}, {16'hFFFF, 16'h0000}, {16'h1234, 16'hEDCB},
    {16'hA55A, 16'h5AA5}, {16'h0F0F, 16'hF0F0}, {16'h8001, 16'h7FFE}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk); cmdValid = 1'b1; cmdByte = b;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] b);
    @(negedge clk); dataValid = 1'b1; dataIn = b;
    @(negedge clk); dataValid = 1'b0;
  endtask

  task automatic writeCnt(input logic [15:0] v, input logic [1:0] m);
    sendCmd(8'h01);
    sendData(v[15:8]);
    sendData(v[7:0]);
    sendData({6'b0, m});
  endtask

  // returns {valid1, valid2, valid3, hi, lo}
  task automatic readCnt(output logic [2:0] vld, output logic [15:0] val);
    sendCmd(8'h03);
    vld[2] = rdValid; val[15:8] = rdData;
    @(negedge clk);
    vld[1] = rdValid; val[7:0] = rdData;
    @(negedge clk);
    vld[0] = rdValid;
  endtask

  task automatic readOne(input logic [7:0] c, output logic v, output logic [7:0] d);
    sendCmd(c);
    v = rdValid; d = rdData;
    @(negedge clk);
  endtask

  task automatic expectCnt(input logic [15:0] exp, input string tag);
    logic [2:0] vld; logic [15:0] val;
    readCnt(vld, val);
    check(vld == 3'b110, {tag, " valid"}, vld, 3'b110);
    check(val == exp, tag, val, exp);
  endtask

  initial begin
    logic v; logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    check(brkReq == 1'b0, "R1 brkReq", brkReq, 0);
    rst = 1'b0;
    readOne(8'h02, v, d);
    check(v && d == 8'h01, "R1 status mode idle", d, 8'h01);
    expectCnt(16'hFFFF, "R1 counter zero");

    // R4 R5 table walk
    for (int i = 0; i < 6; i++) begin
      writeCnt(VEC[i][31:16], 2'd0);
      expectCnt(VEC[i][15:0], "R4 R5 write/read");
    end

    // R2 revision, both modes
    readOne(8'h00, v, d);
    check(v && d == 8'h4C, "R2 revision dbg", d, 8'h4C);
    debugMode = 1'b0;
    readOne(8'h00, v, d);
    check(v && d == 8'h4C, "R2 revision run", d, 8'h4C);
    // R3 status outside debug mode
    readOne(8'h02, v, d);
    check(v && d == 8'h00, "R3 status run idle", d, 8'h00);

    // R10 gating: counter holds 8001h from table
    sendCmd(8'h03);
    check(rdValid == 1'b0, "R10 read gated", rdValid, 0);
    writeCnt(16'h0000, 2'd1);
    debugMode = 1'b1;
    readOne(8'h02, v, d);
    check(d == 8'h01, "R10 mode unchanged", d, 8'h01);
    expectCnt(16'h7FFE, "R10 write gated");
    sendCmd(8'h07);
    check(rdValid == 1'b0, "R10 unknown cmd silent", rdValid, 0);
    sendCmd(8'hFF);
    check(rdValid == 1'b0, "R10 cmd FF silent", rdValid, 0);
    // idle mode ignores strobes
    @(negedge clk); xferByte = 1'b1; cpuRun = 1'b1;
    repeat (5) @(negedge clk);
    xferByte = 1'b0; cpuRun = 1'b0;
    expectCnt(16'h7FFE, "R10 idle ignores strobes");

    // R6 byte counting
    writeCnt(16'h0010, 2'd1);
    readOne(8'h02, v, d);
    check(d == 8'h03, "R3 status bytes mode", d, 8'h03);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); xferByte = 1'b1;
      @(negedge clk); xferByte = 1'b0;
    end
    expectCnt(16'hFFF3, "R6 four bytes");
    writeCnt(16'h0003, 2'd1);
    @(negedge clk); xferByte = 1'b1;
    repeat (5) @(negedge clk);
    xferByte = 1'b0;
    expectCnt(16'hFFFF, "R6 hold at zero");

    // R7 cycle counting
    writeCnt(16'h1234, 2'd2);
    expectCnt(16'h0000, "R7 loads FFFF");
    @(negedge clk); cpuRun = 1'b1;
    repeat (100) @(negedge clk);
    cpuRun = 1'b0;
    expectCnt(16'h0064, "R7 100 cycles");
    readOne(8'h02, v, d);
    check(d == 8'h05, "R3 status cycles mode", d, 8'h05);
    @(negedge clk); cpuRun = 1'b1;
    repeat (65600) @(negedge clk);
    cpuRun = 1'b0;
    expectCnt(16'hFFFF, "R7 hold at zero");

    // R8 breakpoint
    writeCnt(16'h1234, 2'd3);
    @(negedge clk); cpuRun = 1'b1; pc = 16'h1000; fetchStrobe = 1'b1;
    repeat (10) @(negedge clk);
    check(brkReq == 1'b0, "R8 no match", brkReq, 0);
    cpuRun = 1'b0; pc = 16'h1234;
    #1 check(brkReq == 1'b0, "R8 stopped core no break", brkReq, 0);
    @(negedge clk);
    expectCnt(16'hEDCB, "R8 count held");
    @(negedge clk); cpuRun = 1'b1; pc = 16'h1234; fetchStrobe = 1'b1;
    #1 check(brkReq == 1'b1, "R8 break on match", brkReq, 1);
    @(negedge clk);
    #1 check(brkReq == 1'b0, "R8 single pulse", brkReq, 0);
    fetchStrobe = 1'b0; cpuRun = 1'b0;
    readOne(8'h02, v, d);
    check(d == 8'h01, "R8 mode back to idle", d, 8'h01);

    // R1 reset mid-use
    writeCnt(16'h5555, 2'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);
    rst = 1'b0;
    readOne(8'h02, v, d);
    check(d == 8'h01, "R1 mode idle after reset", d, 8'h01);
    expectCnt(16'hFFFF, "R1 counter cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule